// File: doc/BRIEF.md
# USB endpoint handshake responder

This block sits behind the token decoder of a full-speed USB device that has four endpoints. For every decoded token it picks the device's answer. The answer is one of: silence, ACK, NAK, STALL, a data phase or a zero-length data phase. The choice comes from a per-endpoint control word that a processor writes over a simple register port. The block also keeps the 7-bit device address and captures the 11-bit frame number carried by start-of-frame tokens.

A packet engine outside this block serializes the answer. When a data phase that the block accepted has finished, the engine reports it with a completion strobe. On that strobe the block disarms the endpoint concerned and raises a one-cycle done flag for it. Endpoint 0 is the default control pipe and always takes a SETUP token while it is enabled. Endpoints 1 to 3 carry bulk, interrupt or isochronous traffic. In isochronous mode an endpoint never returns a handshake.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset, all four control words, the device address and the frame number read as 0, `rsp_code` is NONE (0) and `ep_done` is 0.
- R2: `reg_addr` values 0 to 3 select the control word of endpoint 0 to 3. In the control word, bit0 is ARM, bit1 is ENABLE, bit2 is DIR (1 = IN, 0 = OUT), bit3 is ISO, bit4 is STALL and bit5 is ZERO_LENGTH. Bits 15 to 6 read as 0. `reg_addr` 4 selects the device address in bits 6 to 0, with the upper bits reading as 0. `reg_addr` 5 returns the frame number in bits 10 to 0 and ignores writes.
- R3: A token of kind OUT (0), IN (1) or SETUP (2) whose `tok_addr` differs from the device address gets NONE and changes no control word.
- R4: A token to an endpoint whose ENABLE bit is 0 gets NONE and changes nothing.
- R5: On an enabled, non-isochronous endpoint with STALL set, the next token gets STALL (3) and the STALL bit clears.
- R6: On an enabled, non-isochronous endpoint with matching direction, no STALL and ARM at 0, the token gets NAK (2).
- R7: An armed IN endpoint answers an IN token with DATA (4), or with ZLP (5) when ZERO_LENGTH is set.
- R8: An armed OUT endpoint answers an OUT token with ACK (1).
- R9: On a non-isochronous endpoint, an IN token to an OUT endpoint gets STALL. So does an OUT or SETUP token to an IN endpoint (except SETUP to endpoint 0, see R12).
- R10: With ISO set, the endpoint never answers NAK or STALL (it gets NONE instead) and leaves its STALL bit alone. An armed, direction-matching ISO endpoint still takes the transfer: IN gets DATA or ZLP, OUT gets NONE.
- R11: A `phase_done` strobe while an accepted transfer is pending does three things: it clears ARM and ZERO_LENGTH of that endpoint, pulses that endpoint's bit of `ep_done` for one cycle in the next cycle, and ends the pending state. A strobe with nothing pending has no effect.
- R12: A SETUP token to an enabled endpoint 0 gets ACK whatever its ARM, STALL and DIR bits are, clears its STALL bit and becomes the pending transfer.
- R13: An SOF token (kind 3) loads `tok_frame` into the frame register whatever its address, and gets NONE.
- R14: The response appears on `rsp_code`/`rsp_ep` in the cycle after the token and lasts one cycle. A register write in the same cycle as a hardware clear of that control word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_pid | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 SOF |
| tok_addr | input | 7 | Device address carried by the token |
| tok_ep | input | 2 | Endpoint number carried by the token |
| tok_frame | input | 11 | Frame number carried by an SOF token |
| phase_done | input | 1 | Pending data phase has completed |
| rsp_code | output | 3 | Response: 0 NONE, 1 ACK, 2 NAK, 3 STALL, 4 DATA, 5 ZLP |
| rsp_ep | output | 2 | Endpoint the response belongs to |
| ep_done | output | 4 | One-cycle transfer-complete flag per endpoint |

## Verification
The assertions check on every cycle that `ep_done` is at most one-hot and only follows a completion strobe, and that a response only follows a token and is a legal code. They also check that a hardware clear really drops ARM or STALL, that a register write always lands, and that the frame and address registers take the values presented. Only the bench's scenarios can show the priority among disable, address mismatch, STALL, direction mismatch and NAK. The same goes for the suppression of handshakes in isochronous mode, the SETUP override on endpoint 0, and readback with zeroed upper bits, because these depend on the contents of the control words that a sequence of writes and tokens has built up.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  typedef enum logic [1:0] {
    PID_OUT   = 2'd0,
    PID_IN    = 2'd1,
    PID_SETUP = 2'd2,
    PID_SOF   = 2'd3
  } tok_kind_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA  = 3'd4,
    RSP_ZLP   = 3'd5
  } rsp_e;

  // Packed MSB first: zlp is bit5, arm is bit0.
  typedef struct packed {
    logic zlp;
    logic stall;
    logic iso;
    logic dir;
    logic enable;
    logic arm;
  } ep_ctrl_t;

  localparam int CTRL_W = $bits(ep_ctrl_t);

endpackage

// File: rtl/usb_ep_ctrl_bank.sv
module usb_ep_ctrl_bank
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_EP-1:0]       wr_en,
  input  ep_ctrl_t                wdata,
  input  logic [NUM_EP-1:0]       clr_arm,
  input  logic [NUM_EP-1:0]       clr_stall,
  output ep_ctrl_t [NUM_EP-1:0]   ctrl_q
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_ctrl_t ctrl_nxt;
    logic     ctrl_en;

    always_comb begin
      ctrl_nxt = ctrl_q[i];
      if (clr_arm[i]) begin
        ctrl_nxt.arm = 1'b0;
        ctrl_nxt.zlp = 1'b0;
      end
      if (clr_stall[i]) begin
        ctrl_nxt.stall = 1'b0;
      end
      if (wr_en[i]) begin
        ctrl_nxt = wdata;
      end
      ctrl_en = wr_en[i] | clr_arm[i] | clr_stall[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[i] <= '0;
      end else if (ctrl_en) begin
        ctrl_q[i] <= ctrl_nxt;
      end
    end

    // R11: completion drops ARM unless software rewrites in the same cycle
    a_r11_arm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_arm[i] && !wr_en[i]) |=> !ctrl_q[i].arm);

    // R5: an issued stall is consumed
    a_r5_stall_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stall[i] && !wr_en[i]) |=> !ctrl_q[i].stall);

    // R14: a write always lands, even against a hardware clear
    a_r14_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> (ctrl_q[i] == $past(wdata)));
  end

endmodule

// File: rtl/usb_ep_dev_regs.sv
module usb_ep_dev_regs #(
  parameter int ADDR_W  = 7,
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_wr,
  input  logic [ADDR_W-1:0]  addr_wdata,
  input  logic               sof_seen,
  input  logic [FRAME_W-1:0] sof_frame,
  output logic [ADDR_W-1:0]  dev_addr,
  output logic [FRAME_W-1:0] frame_num
);

  logic [ADDR_W-1:0]  addr_nxt;
  logic [FRAME_W-1:0] frame_nxt;

  always_comb begin
    addr_nxt  = addr_wr  ? addr_wdata : dev_addr;
    frame_nxt = sof_seen ? sof_frame  : frame_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr <= '0;
    end else if (addr_wr) begin
      dev_addr <= addr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_num <= '0;
    end else if (sof_seen) begin
      frame_num <= frame_nxt;
    end
  end

  // R13: SOF captures the carried frame number
  a_r13_frame_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen |=> (frame_num == $past(sof_frame)));

  // R2: device address takes the written value
  a_r2_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (dev_addr == $past(addr_wdata)));

endmodule

// File: rtl/usb_ep_decide.sv
module usb_ep_decide
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2
) (
  input  logic                  tok_valid,
  input  logic [1:0]            tok_pid,
  input  logic                  addr_match,
  input  logic [EP_W-1:0]       tok_ep,
  input  ep_ctrl_t [NUM_EP-1:0] ctrl,
  output rsp_e                  rsp,
  output logic                  accept,
  output logic [NUM_EP-1:0]     clr_stall
);

  logic     ep_ok;
  logic     dir_in;
  logic     dir_match;
  logic     is_setup0;
  ep_ctrl_t cur;

  always_comb begin
    ep_ok     = ({1'b0, tok_ep} < (EP_W+1)'(NUM_EP));
    cur       = ep_ok ? ctrl[tok_ep] : '0;
    dir_in    = (tok_pid == PID_IN);
    dir_match = (cur.dir == dir_in);
    is_setup0 = (tok_pid == PID_SETUP) && (tok_ep == '0);

    rsp       = RSP_NONE;
    accept    = 1'b0;
    clr_stall = '0;

    if (tok_valid && (tok_pid != PID_SOF) && addr_match && ep_ok && cur.enable) begin
      if (is_setup0) begin
        rsp          = RSP_ACK;
        accept       = 1'b1;
        clr_stall[0] = 1'b1;
      end else if (cur.iso) begin
        if (cur.arm && dir_match) begin
          accept = 1'b1;
          if (dir_in) begin
            rsp = cur.zlp ? RSP_ZLP : RSP_DATA;
          end
        end
      end else if (cur.stall) begin
        rsp               = RSP_STALL;
        clr_stall[tok_ep] = 1'b1;
      end else if (!dir_match) begin
        rsp = RSP_STALL;
      end else if (!cur.arm) begin
        rsp = RSP_NAK;
      end else begin
        accept = 1'b1;
        if (dir_in) begin
          rsp = cur.zlp ? RSP_ZLP : RSP_DATA;
        end else begin
          rsp = RSP_ACK;
        end
      end
    end
  end

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 7,
  parameter int FRAME_W = 11,
  localparam int EP_W   = $clog2(NUM_EP),
  localparam int REG_AW = $clog2(NUM_EP + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               tok_valid,
  input  logic [1:0]         tok_pid,
  input  logic [ADDR_W-1:0]  tok_addr,
  input  logic [EP_W-1:0]    tok_ep,
  input  logic [FRAME_W-1:0] tok_frame,
  input  logic               phase_done,
  output logic [2:0]         rsp_code,
  output logic [EP_W-1:0]    rsp_ep,
  output logic [NUM_EP-1:0]  ep_done
);

  localparam logic [REG_AW-1:0] SEL_DEVADDR = REG_AW'(NUM_EP);
  localparam logic [REG_AW-1:0] SEL_FRAME   = REG_AW'(NUM_EP + 1);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // Register port decode
  logic [NUM_EP-1:0] wr_ctrl;
  logic              wr_devaddr;
  logic              unused_wdata_hi;

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      wr_ctrl[i] = reg_wr && (reg_addr == REG_AW'(i));
    end
    wr_devaddr = reg_wr && (reg_addr == SEL_DEVADDR);
  end
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:ADDR_W];

  // Sub-blocks
  ep_ctrl_t [NUM_EP-1:0] ctrl_q;
  logic [NUM_EP-1:0]     clr_arm;
  logic [NUM_EP-1:0]     clr_stall;
  logic [ADDR_W-1:0]     dev_addr;
  logic [FRAME_W-1:0]    frame_num;
  logic                  sof_seen;
  rsp_e                  rsp_dec;
  logic                  accept;

  assign sof_seen = tok_valid && (tok_pid == PID_SOF);

  usb_ep_ctrl_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_ctrl),
    .wdata     (ep_ctrl_t'(reg_wdata[CTRL_W-1:0])),
    .clr_arm   (clr_arm),
    .clr_stall (clr_stall),
    .ctrl_q    (ctrl_q)
  );

  usb_ep_dev_regs #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_dev (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_wr    (wr_devaddr),
    .addr_wdata (reg_wdata[ADDR_W-1:0]),
    .sof_seen   (sof_seen),
    .sof_frame  (tok_frame),
    .dev_addr   (dev_addr),
    .frame_num  (frame_num)
  );

  usb_ep_decide #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_decide (
    .tok_valid  (tok_valid),
    .tok_pid    (tok_pid),
    .addr_match (tok_addr == dev_addr),
    .tok_ep     (tok_ep),
    .ctrl       (ctrl_q),
    .rsp        (rsp_dec),
    .accept     (accept),
    .clr_stall  (clr_stall)
  );

  // Pending transfer and response registers
  rsp_e              rsp_q,      rsp_nxt;
  logic [EP_W-1:0]   rsp_ep_q,   rsp_ep_nxt;
  logic              pend_vld_q, pend_vld_nxt;
  logic [EP_W-1:0]   pend_ep_q,  pend_ep_nxt;
  logic [NUM_EP-1:0] done_q,     done_nxt;

  always_comb begin
    done_nxt = '0;
    if (phase_done && pend_vld_q) begin
      done_nxt[pend_ep_q] = 1'b1;
    end
    clr_arm = done_nxt;

    rsp_nxt    = rsp_dec;
    rsp_ep_nxt = (rsp_dec != RSP_NONE) ? tok_ep : rsp_ep_q;

    pend_vld_nxt = pend_vld_q;
    pend_ep_nxt  = pend_ep_q;
    if (phase_done) begin
      pend_vld_nxt = 1'b0;
    end
    if (accept) begin
      pend_vld_nxt = 1'b1;
      pend_ep_nxt  = tok_ep;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_q      <= RSP_NONE;
      rsp_ep_q   <= '0;
      pend_vld_q <= 1'b0;
      pend_ep_q  <= '0;
      done_q     <= '0;
    end else begin
      rsp_q      <= rsp_nxt;
      rsp_ep_q   <= rsp_ep_nxt;
      pend_vld_q <= pend_vld_nxt;
      pend_ep_q  <= pend_ep_nxt;
      done_q     <= done_nxt;
    end
  end

  assign rsp_code = rsp_q;
  assign rsp_ep   = rsp_ep_q;
  assign ep_done  = done_q;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if ({1'b0, reg_addr} < (REG_AW+1)'(NUM_EP)) begin
      reg_rdata[CTRL_W-1:0] = ctrl_q[reg_addr[EP_W-1:0]];
    end else if (reg_addr == SEL_DEVADDR) begin
      reg_rdata[ADDR_W-1:0] = dev_addr;
    end else if (reg_addr == SEL_FRAME) begin
      reg_rdata[FRAME_W-1:0] = frame_num;
    end
  end

  // R11: at most one endpoint completes per cycle
  a_r11_done_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ep_done));

  // R11: a done flag only follows a completion strobe
  a_r11_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ep_done != '0) |-> $past(phase_done));

  // R14: a response only follows a token
  a_r14_rsp_after_token: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_code != 3'd0) |-> $past(tok_valid));

  // R14: only defined response codes appear
  a_r14_code_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_code <= 3'd5);

endmodule

// File: tb/usb_ep_responder_bench.sv
module usb_ep_responder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        tok_valid;
  logic [1:0]  tok_pid;
  logic [6:0]  tok_addr;
  logic [1:0]  tok_ep;
  logic [10:0] tok_frame;
  logic        phase_done;
  logic [2:0]  rsp_code;
  logic [1:0]  rsp_ep;
  logic [3:0]  ep_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2, K_SOF = 2'd3;
  localparam logic [2:0] C_NONE = 3'd0, C_ACK = 3'd1, C_NAK = 3'd2,
                         C_STALL = 3'd3, C_DATA = 3'd4, C_ZLP = 3'd5;
  localparam logic [6:0] MY_ADDR = 7'h15;

  usb_ep_responder u_usb_ep_responder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
    .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .tok_frame(tok_frame), .phase_done(phase_done), .rsp_code(rsp_code),
    .rsp_ep(rsp_ep), .ep_done(ep_done)
  );

  always #2.5 clk = ~clk;

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = sel;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic tok_check(input logic [1:0] kind, input logic [6:0] adr,
                           input logic [1:0] ep, input logic [2:0] exp, input string tag);
    @(negedge clk);
    tok_valid = 1'b1; tok_pid = kind; tok_addr = adr; tok_ep = ep;
    @(negedge clk);
    tok_valid = 1'b0;
    check(rsp_code == exp, tag, {13'd0, rsp_code}, {13'd0, exp});
    if (exp != C_NONE) check(rsp_ep == ep, tag, {14'd0, rsp_ep}, {14'd0, ep});
    @(negedge clk);
    check(rsp_code == C_NONE, "R14 one-cycle response", {13'd0, rsp_code}, 16'd0);
  endtask

  task automatic done_check(input logic [3:0] exp, input string tag);
    @(negedge clk);
    phase_done = 1'b1;
    @(negedge clk);
    phase_done = 1'b0;
    check(ep_done == exp, tag, {12'd0, ep_done}, {12'd0, exp});
    @(negedge clk);
    check(ep_done == 4'd0, "R11 done lasts one cycle", {12'd0, ep_done}, 16'd0);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 6; s++) rd_check(3'(s), 16'h0000, "R1 register after reset");
    check(rsp_code == C_NONE, "R1 rsp after reset", {13'd0, rsp_code}, 16'd0);
    check(ep_done == 4'd0, "R1 ep_done after reset", {12'd0, ep_done}, 16'd0);
  endtask

  task automatic t_regs();
    wr_reg(3'd1, 16'hFFFF);
    rd_check(3'd1, 16'h003F, "R2 control word upper bits zero");
    wr_reg(3'd4, 16'hFFFF);
    rd_check(3'd4, 16'h007F, "R2 address width");
    wr_reg(3'd5, 16'h1234);
    rd_check(3'd5, 16'h0000, "R2 frame register read-only");
    wr_reg(3'd4, {9'd0, MY_ADDR});
    rd_check(3'd4, 16'h0015, "R2 address readback");
  endtask

  task automatic t_addr_and_in();
    wr_reg(3'd1, 16'h0007);
    tok_check(K_IN, 7'h14, 2'd1, C_NONE, "R3 foreign address ignored");
    rd_check(3'd1, 16'h0007, "R3 control word untouched");
    tok_check(K_IN, MY_ADDR, 2'd1, C_DATA, "R7 armed IN gives DATA");
    done_check(4'b0010, "R11 done flag ep1");
    rd_check(3'd1, 16'h0006, "R11 ARM cleared");
    tok_check(K_IN, MY_ADDR, 2'd1, C_NAK, "R6 unarmed gives NAK");
    wr_reg(3'd1, 16'h0027);
    tok_check(K_IN, MY_ADDR, 2'd1, C_ZLP, "R7 zero-length request gives ZLP");
    done_check(4'b0010, "R11 done flag after ZLP");
    rd_check(3'd1, 16'h0006, "R11 ARM and ZERO_LENGTH cleared");
  endtask

  task automatic t_out_paths();
    wr_reg(3'd2, 16'h0001);
    tok_check(K_OUT, MY_ADDR, 2'd2, C_NONE, "R4 disabled endpoint silent");
    rd_check(3'd2, 16'h0001, "R4 control word untouched");
    wr_reg(3'd2, 16'h0003);
    tok_check(K_OUT, MY_ADDR, 2'd2, C_ACK, "R8 armed OUT gives ACK");
    done_check(4'b0100, "R11 done flag ep2");
    rd_check(3'd2, 16'h0002, "R11 ARM cleared on OUT");
    wr_reg(3'd2, 16'h0003);
    tok_check(K_IN, MY_ADDR, 2'd2, C_STALL, "R9 IN to OUT endpoint stalls");
    rd_check(3'd2, 16'h0003, "R9 ARM kept after mismatch");
    wr_reg(3'd2, 16'h0013);
    tok_check(K_OUT, MY_ADDR, 2'd2, C_STALL, "R5 stall answered");
    rd_check(3'd2, 16'h0003, "R5 stall consumed");
    tok_check(K_OUT, MY_ADDR, 2'd2, C_ACK, "R5 next token after stall");
    done_check(4'b0100, "R11 done after post-stall ACK");
  endtask

  task automatic t_iso();
    wr_reg(3'd3, 16'h000E);
    tok_check(K_IN, MY_ADDR, 2'd3, C_NONE, "R10 iso unarmed no NAK");
    wr_reg(3'd3, 16'h001E);
    tok_check(K_IN, MY_ADDR, 2'd3, C_NONE, "R10 iso no STALL");
    rd_check(3'd3, 16'h001E, "R10 iso stall bit kept");
    wr_reg(3'd3, 16'h000F);
    tok_check(K_IN, MY_ADDR, 2'd3, C_DATA, "R10 iso armed IN gives DATA");
    done_check(4'b1000, "R10 iso IN completes");
    rd_check(3'd3, 16'h000E, "R10 iso ARM cleared");
    wr_reg(3'd3, 16'h000B);
    tok_check(K_OUT, MY_ADDR, 2'd3, C_NONE, "R10 iso OUT silent");
    done_check(4'b1000, "R10 iso OUT still completes");
    rd_check(3'd3, 16'h000A, "R10 iso OUT ARM cleared");
  endtask

  task automatic t_setup();
    tok_check(K_SETUP, MY_ADDR, 2'd0, C_NONE, "R4 SETUP to disabled ep0");
    wr_reg(3'd0, 16'h0016);
    tok_check(K_SETUP, MY_ADDR, 2'd0, C_ACK, "R12 SETUP ep0 accepted");
    rd_check(3'd0, 16'h0006, "R12 SETUP clears STALL");
    tok_check(K_SETUP, MY_ADDR, 2'd1, C_STALL, "R9 SETUP to IN ep1 stalls");
    done_check(4'b0001, "R12 SETUP pending completes");
    done_check(4'b0000, "R11 strobe with nothing pending");
  endtask

  task automatic t_sof();
    @(negedge clk);
    tok_valid = 1'b1; tok_pid = K_SOF; tok_addr = 7'h00; tok_ep = 2'd0; tok_frame = 11'h5A3;
    @(negedge clk);
    tok_valid = 1'b0;
    check(rsp_code == C_NONE, "R13 SOF gives no response", {13'd0, rsp_code}, 16'd0);
    rd_check(3'd5, 16'h05A3, "R13 frame captured");
    tok_frame = 11'h7FF;
    tok_check(K_SOF, 7'h33, 2'd2, C_NONE, "R13 SOF any address");
    rd_check(3'd5, 16'h07FF, "R13 frame max value");
  endtask

  task automatic t_write_race();
    wr_reg(3'd1, 16'h0007);
    tok_check(K_IN, MY_ADDR, 2'd1, C_DATA, "R14 race setup DATA");
    @(negedge clk);
    phase_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0027;
    @(negedge clk);
    phase_done = 1'b0; reg_wr = 1'b0;
    check(ep_done == 4'b0010, "R11 done during write", {12'd0, ep_done}, 16'h0002);
    rd_check(3'd1, 16'h0027, "R14 write wins over clear");
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tok_valid = 1'b0; tok_pid = '0; tok_addr = '0; tok_ep = '0; tok_frame = '0;
    phase_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_addr_and_in();
    t_out_paths();
    t_iso();
    t_setup();
    t_sof();
    t_write_race();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule